// File: doc/BRIEF.md
# Selective Victim Bank Filter

This block is one extra bank placed beside the banks of a distributed shared cache. When a main bank throws a line out, the line arrives on the eviction port with its line address, its data, a dirty flag and an origin flag. The origin flag tells whether the line left a local bank or a central bank. A line from a local bank is kept in the victim bank. A line from any other bank class skips the bank and goes straight to the main-memory writeback port.

The victim bank is set-associative, with least-recently-inserted replacement inside each set. The main banks send their misses to the lookup port. A hit returns the line and its dirty flag so that it can go back into the main cache. The hit also removes the line from the victim bank, so no second copy stays behind. A lookup and an eviction that arrive in the same cycle are resolved in favour of the lookup: the eviction sees `ev_ready` low and waits. Every access takes two cycles from acceptance to its result at the outputs.

Top module: `vb_victim_bank`

## Requirements
- R1: After reset the bank is empty. Every lookup misses, `rsp_valid` and `wb_valid` are low, and `ev_ready` is high while no lookup is presented.
- R2: An eviction accepted with `ev_from_local` = 0 is not stored. It appears on `wb_valid`/`wb_addr`/`wb_data` with its own address and data, and a later lookup of that address misses.
- R3: An eviction accepted with `ev_from_local` = 1 is stored. A later lookup of the same line address returns `rsp_hit` = 1 together with the stored data and dirty flag.
- R4: A request present on the inputs in cycle t gives its result (`rsp_*` for a lookup, `wb_*` for a writeback) in cycle t+2. In cycle t+1 neither output is valid, and `rsp_valid` is raised only for lookups.
- R5: A lookup that hits removes the line from the bank, so a second lookup of the same address misses.
- R6: An admitted line that maps to a set with a free way fills that way and causes no writeback.
- R7: An admitted line that maps to a full set displaces the way filled longest ago. The displaced line is sent to the writeback port only if its dirty flag is set; a clean displaced line is dropped.
- R8: When `lk_valid` and `ev_valid` are both high in one cycle, `ev_ready` is low and the lookup is served. The held eviction is accepted in a later cycle and is not lost.
- R9: The set index is the low log2(SETS) bits of the line address and the tag is the rest. Lines in different sets never displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Evicted line offered |
| ev_ready | output | 1 | Eviction accepted this cycle |
| ev_addr | input | AW | Line address of the evicted line |
| ev_data | input | DW | Data of the evicted line |
| ev_dirty | input | 1 | Evicted line differs from memory |
| ev_from_local | input | 1 | 1 = evicted from a local bank, 0 = any other bank class |
| lk_valid | input | 1 | Lookup request (always accepted) |
| lk_addr | input | AW | Line address to look up |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_dirty | output | 1 | Dirty flag of the returned line |
| rsp_data | output | DW | Data of the returned line |
| wb_valid | output | 1 | Line to be written to main memory |
| wb_addr | output | AW | Line address of the writeback |
| wb_data | output | DW | Data of the writeback |

## Verification
The assertions assume three things about the inputs: a held eviction keeps its address, data and flags steady until `ev_ready` accepts it, lookups are single-cycle pulses, and no input is active during reset. They also assume the main cache never evicts a line that the victim bank still holds. The bank tolerates that case by overwriting the matching way, but the assertions do not depend on it. The stimulus drives every request for exactly one cycle on the falling edge and keeps the eviction fields unchanged across a stall. It uses a distinct line address for every line inserted, so each admitted line lands in a free way or displaces an older one.

// File: rtl/vb_pkg.sv
package vb_pkg;

  // Operation latched into the access stage; the filter decision is encoded here.
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_ADMIT  = 2'd2,
    OP_BYPASS = 2'd3
  } op_e;

  // Age of one way after a fill in its set: the filled way becomes youngest,
  // ways younger than its former age grow one step older.
  function automatic int unsigned next_age(input int unsigned cur,
                                           input int unsigned filled_age,
                                           input bit          is_filled);
    if (is_filled)            return 0;
    else if (cur < filled_age) return cur + 1;
    else                      return cur;
  endfunction

  // Sum of a full permutation of ages 0..n-1.
  function automatic int unsigned age_sum(input int unsigned n);
    return (n * (n - 1)) / 2;
  endfunction

endpackage

// File: rtl/vb_filter.sv
module vb_filter #(
  parameter int AW = 26,
  parameter int DW = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [AW-1:0]   lk_addr,
  input  logic            ev_valid,
  output logic            ev_ready,
  input  logic [AW-1:0]   ev_addr,
  input  logic [DW-1:0]   ev_data,
  input  logic            ev_dirty,
  input  logic            ev_from_local,
  output vb_pkg::op_e     s1_op,
  output logic [AW-1:0]   s1_addr,
  output logic [DW-1:0]   s1_data,
  output logic            s1_dirty
);
  import vb_pkg::*;

  logic take_ev;
  op_e  op_nxt;

  // Lookups win the single access slot; an eviction waits behind them.
  assign ev_ready = !lk_valid;
  assign take_ev  = ev_valid && !lk_valid;

  always_comb begin
    if (lk_valid)     op_nxt = OP_LOOKUP;
    else if (take_ev) op_nxt = ev_from_local ? OP_ADMIT : OP_BYPASS;
    else              op_nxt = OP_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_dirty <= 1'b0;
    end else begin
      s1_op <= op_nxt;
      if (lk_valid) s1_addr <= lk_addr;
      else if (take_ev) begin
        s1_addr  <= ev_addr;
        s1_dirty <= ev_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_ev) s1_data <= ev_data;
  end

  // R8
  held_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && ev_valid) |=> (s1_op == OP_LOOKUP));

endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] oldest_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[set_i][w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (fill_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[set_i][w] <= WAY_W'(vb_pkg::next_age(32'(age_q[set_i][w]),
                                                    32'(age_q[set_i][fill_way]),
                                                    (w == int'(fill_way))));
    end
  end

  // R7: ages in every set stay a permutation, so exactly one way is oldest.
  always @(posedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        int unsigned acc;
        acc = 0;
        for (int w = 0; w < WAYS; w++) acc = acc + 32'(age_q[s][w]);
        age_perm_chk: assert (acc == vb_pkg::age_sum(WAYS))
          else $error("age permutation broken in set %0d", s);
      end
    end
  end

endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int AW   = 26,
  parameter int DW   = 512,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = AW - SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic             all_valid,
  output logic [WAY_W-1:0] free_way,
  input  logic [WAY_W-1:0] sel_way,
  output logic [TAG_W-1:0] sel_tag,
  output logic [DW-1:0]    sel_data,
  output logic             sel_dirty,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [DW-1:0]    wr_data,
  input  logic             wr_dirty,
  input  logic             inv_en,
  input  logic [WAY_W-1:0] inv_way
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS*WAYS];
  logic             dirty_q [SETS*WAYS];
  logic [DW-1:0]    data_q  [SETS*WAYS];

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[set_i][w] && tag_q[{set_i, WAY_W'(w)}] == tag_i) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_q[set_i][w]) free_way = WAY_W'(w);
  end

  assign all_valid = &valid_q[set_i];
  assign sel_tag   = tag_q[{set_i, sel_way}];
  assign sel_data  = data_q[{set_i, sel_way}];
  assign sel_dirty = dirty_q[{set_i, sel_way}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (wr_en)  valid_q[set_i][wr_way]  <= 1'b1;
      if (inv_en) valid_q[set_i][inv_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[{set_i, wr_way}]   <= tag_i;
      dirty_q[{set_i, wr_way}] <= wr_dirty;
      data_q[{set_i, wr_way}]  <= wr_data;
    end
  end

  // R5
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !valid_q[$past(set_i)][$past(inv_way)]);

endmodule

// File: rtl/vb_victim_bank.sv
module vb_victim_bank #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int AW   = 26,
  parameter int DW   = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  input  logic          ev_dirty,
  input  logic          ev_from_local,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_dirty,
  output logic [DW-1:0] rsp_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  import vb_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = AW - SET_W;

  op_e              s1_op;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    s1_data;
  logic             s1_dirty;
  logic [SET_W-1:0] s1_set;
  logic [TAG_W-1:0] s1_tag;

  logic             hit, all_valid, sel_dirty;
  logic [WAY_W-1:0] hit_way, free_way, oldest_way, fill_way, sel_way;
  logic [TAG_W-1:0] sel_tag;
  logic [DW-1:0]    sel_data;

  // Named events of the access stage.
  logic lk_hit_evt, admit_evt, bypass_evt, displace_evt, dirty_out_evt;

  vb_filter #(.AW(AW), .DW(DW)) u_filter (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_dirty(ev_dirty), .ev_from_local(ev_from_local),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_data(s1_data), .s1_dirty(s1_dirty)
  );

  assign s1_set = s1_addr[SET_W-1:0];
  assign s1_tag = s1_addr[AW-1:SET_W];

  assign lk_hit_evt    = (s1_op == OP_LOOKUP) && hit;
  assign admit_evt     = (s1_op == OP_ADMIT);
  assign bypass_evt    = (s1_op == OP_BYPASS);
  assign fill_way      = hit ? hit_way : (!all_valid ? free_way : oldest_way);
  assign displace_evt  = admit_evt && !hit && all_valid;
  assign dirty_out_evt = displace_evt && sel_dirty;
  assign sel_way       = (s1_op == OP_LOOKUP) ? hit_way : fill_way;

  vb_store #(.SETS(SETS), .WAYS(WAYS), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .set_i(s1_set), .tag_i(s1_tag),
    .hit(hit), .hit_way(hit_way), .all_valid(all_valid), .free_way(free_way),
    .sel_way(sel_way), .sel_tag(sel_tag), .sel_data(sel_data), .sel_dirty(sel_dirty),
    .wr_en(admit_evt), .wr_way(fill_way), .wr_data(s1_data),
    .wr_dirty(s1_dirty || (hit && sel_dirty)),
    .inv_en(lk_hit_evt), .inv_way(hit_way)
  );

  vb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .set_i(s1_set), .fill_en(admit_evt), .fill_way(fill_way),
    .oldest_way(oldest_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dirty <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
    end else begin
      rsp_valid <= (s1_op == OP_LOOKUP);
      rsp_hit   <= lk_hit_evt;
      rsp_dirty <= lk_hit_evt && sel_dirty;
      wb_valid  <= bypass_evt || dirty_out_evt;
      wb_addr   <= bypass_evt ? s1_addr : {sel_tag, s1_set};
    end
  end

  always_ff @(posedge clk) begin
    rsp_data <= sel_data;
    wb_data  <= bypass_evt ? s1_data : sel_data;
  end

  // R4
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid, 2));

  // R2
  bypass_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_valid && ev_ready && !ev_from_local, 2) |-> (wb_valid && wb_addr == $past(ev_addr, 2)));

  // R6
  free_way_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (admit_evt && !all_valid) |=> !wb_valid);

  // R3
  hit_has_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

endmodule

// File: tb/vb_victim_bank_bench.sv
`timescale 1ns/1ps
module vb_victim_bank_bench;
  localparam int AW = 26;
  localparam int DW = 512;
  localparam int NROWS = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0, ev_dirty = 1'b0, ev_from_local = 1'b0;
  logic [AW-1:0] ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic          ev_ready;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vb_victim_bank #(.SETS(16), .WAYS(4), .AW(AW), .DW(DW)) u_vb_victim_bank (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_dirty(ev_dirty), .ev_from_local(ev_from_local),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  typedef struct packed {
    logic        is_ev;
    logic        loc;
    logic        dty;
    logic        e_hit;
    logic        e_hdty;
    logic        e_wb;
    logic [15:0] addr;
    logic [15:0] wb_line;
    logic [7:0]  req;
  } vec_t;

  // Set = addr[3:0]; rows 4..14 all land in set 3.
  localparam vec_t ROWS [NROWS] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h013,16'h000,8'd1}, // R1 empty bank misses
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h025,16'h025,8'd2}, // R2 central victim goes to memory
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h025,16'h000,8'd2}, // R2 not stored
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'h013,16'h000,8'd6}, // R6 free way
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h023,16'h000,8'd6}, // R6
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'h033,16'h000,8'd6}, // R6
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'h043,16'h000,8'd6}, // R6 set now full
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,16'h053,16'h013,8'd7}, // R7 oldest dirty displaced
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'h063,16'h000,8'd7}, // R7 oldest clean dropped
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h013,16'h000,8'd7}, // R7 displaced line gone
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h033,16'h000,8'd3}, // R3 hit, dirty
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h033,16'h000,8'd5}, // R5 removed on hit
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,16'h073,16'h000,8'd6}, // R6 reuses freed way
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,16'h083,16'h043,8'd7}, // R7 next oldest
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h053,16'h000,8'd3}, // R3 hit, clean
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h047,16'h000,8'd9}, // R9 other set empty
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,16'h047,16'h000,8'd9}, // R9 no displacement
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h047,16'h000,8'd9}, // R9 hit in set 7
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h063,16'h000,8'd3}  // R3 survivor still there
  };

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {16{6'h2A, a}};
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_valid = 1'b0;
    lk_valid = 1'b0;
  endtask

  task automatic run_row(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("R%0d row %0d", v.req, idx);
    @(negedge clk);
    if (v.is_ev) begin
      ev_valid = 1'b1; ev_addr = AW'(v.addr); ev_data = pat(AW'(v.addr));
      ev_dirty = v.dty; ev_from_local = v.loc;
    end else begin
      lk_valid = 1'b1; lk_addr = AW'(v.addr);
    end
    @(negedge clk);
    idle_inputs();
    // R4: nothing valid one cycle after the request
    chk(!rsp_valid && !wb_valid, {tag, " R4 early"}, DW'({rsp_valid, wb_valid}), '0);
    @(negedge clk);
    chk(rsp_valid == !v.is_ev, {tag, " rsp_valid"}, DW'(rsp_valid), DW'(!v.is_ev));
    if (!v.is_ev) begin
      chk(rsp_hit == v.e_hit, {tag, " rsp_hit"}, DW'(rsp_hit), DW'(v.e_hit));
      if (v.e_hit) begin
        chk(rsp_data == pat(AW'(v.addr)), {tag, " rsp_data"}, rsp_data, pat(AW'(v.addr)));
        chk(rsp_dirty == v.e_hdty, {tag, " rsp_dirty"}, DW'(rsp_dirty), DW'(v.e_hdty));
      end
    end
    chk(wb_valid == v.e_wb, {tag, " wb_valid"}, DW'(wb_valid), DW'(v.e_wb));
    if (v.e_wb) begin
      chk(wb_addr == AW'(v.wb_line), {tag, " wb_addr"}, DW'(wb_addr), DW'(v.wb_line));
      chk(wb_data == pat(AW'(v.wb_line)), {tag, " wb_data"}, wb_data, pat(AW'(v.wb_line)));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: cycles %0d expected below %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rsp_valid && !wb_valid, "R1 outputs idle in reset", DW'({rsp_valid, wb_valid}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R1 ev_ready after reset", DW'(ev_ready), DW'(1));
    chk(!rsp_valid && !wb_valid, "R1 outputs idle after reset", DW'({rsp_valid, wb_valid}), '0);

    for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

    // R8: lookup and eviction in the same cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = AW'(16'h099);
    ev_valid = 1'b1; ev_addr = AW'(16'h0A9); ev_data = pat(AW'(16'h0A9));
    ev_dirty = 1'b1; ev_from_local = 1'b1;
    #1;
    chk(ev_ready == 1'b0, "R8 eviction stalled", DW'(ev_ready), '0);
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    chk(ev_ready == 1'b1, "R8 eviction taken next", DW'(ev_ready), DW'(1));
    @(negedge clk);
    ev_valid = 1'b0;
    chk(rsp_valid && !rsp_hit, "R8 lookup served first", DW'({rsp_valid, rsp_hit}), DW'(2'b10));
    @(negedge clk);
    chk(!wb_valid && !rsp_valid, "R8 held eviction stored quietly", DW'({rsp_valid, wb_valid}), '0);
    run_row('{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h0A9,16'h000,8'd8}, 100);

    // R4 / R3: lookup right behind the eviction of the same line
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = AW'(16'h0B1); ev_data = pat(AW'(16'h0B1));
    ev_dirty = 1'b0; ev_from_local = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    lk_valid = 1'b1; lk_addr = AW'(16'h0B1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(!rsp_valid && !wb_valid, "R4 eviction gives no output", DW'({rsp_valid, wb_valid}), '0);
    @(negedge clk);
    chk(rsp_valid && rsp_hit, "R3 back-to-back hit", DW'({rsp_valid, rsp_hit}), DW'(2'b11));
    chk(rsp_data == pat(AW'(16'h0B1)), "R3 back-to-back data", rsp_data, pat(AW'(16'h0B1)));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule